// File: doc/BRIEF.md
# Cache-line copy engine

This block copies whole cache lines from one memory region to another. Software programs a source address, a destination address and a notification address through a small register port. It then writes a control word, and that write starts the copy. The engine walks the lines one at a time over a line-wide memory request/response port. Each line is one read followed by one write.

When the copy ends, the engine writes a 64-bit status word to the notification address. Software presets that word to a busy pattern of its own choosing and polls memory instead of the engine. Any value other than the preset means the copy is over. An error response from memory aborts the copy and produces an error status word carrying the memory's error code.

A parameter selects how a copy is started:
- **Combined start:** one control write carries a go flag, the line count and the mode.
- **Split start:** the line count is written to the length/status register first, and a later control write starts the copy.

Top module: `lcopy_engine`

## Requirements
- R1: After reset the engine is idle. It issues no memory request, and the length/status register (index 3) reads zero.
- R2: The engine treats the low 6 bits of the source and destination addresses as zero, and the low 3 bits of the notification address as zero. Register readback shows the masked values. Only the low 16 bits of a supplied line count are used.
- R3: In the combined variant, a control write (index 4) with bit 23 set starts a copy. Bits 15:0 give the line count and bits 31:24 give the mode. A control write with bit 23 clear has no effect. The control register reads the last started mode in bits 7:0.
- R4: In the split variant, a write to the length/status register (index 3) sets the line count, which reads back in bits 15:0. A later control write starts the copy and supplies the mode in bits 7:0.
- R5: Line k of a copy is read from source + 64·k and written with the same data to destination + 64·k. Only one request is outstanding at a time, and a request holds its address until accepted.
- R6: Bit 31 of the length/status register is set from the clock edge that accepts the start until the response to the notification write. While it is clear, no memory request is issued.
- R7: On success the engine issues one 8-byte write (mem_req_word high) to the notification address. The word has bit 63 clear, the number of lines copied in bits 31:16, and bit 0 set.
- R8: An error response stops the copy at once. The notification word has bit 63 set, the lines completed before the error in bits 31:16, and the memory error code in bits 7:0. Lines already written stay written, and later lines are not touched.
- R9: A start command arriving while the engine is active is ignored. It also sets bit 30 of the length/status register, and that bit stays set until reset.
- R10: A copy with a line count of zero makes no line traffic and goes straight to the success notification with a count of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index (0 source, 1 destination, 2 notification, 3 length/status, 4 control) |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Readback of the register selected by reg_addr |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_we | output | 1 | 1 = write, 0 = read |
| mem_req_word | output | 1 | 1 = 8-byte notification write, 0 = full line |
| mem_req_addr | output | 40 | Byte address of the request |
| mem_req_wdata | output | 512 | Write data (line, or status word in bits 63:0) |
| mem_rsp_valid | input | 1 | Response for the outstanding request |
| mem_rsp_err | input | 1 | Response reports an error |
| mem_rsp_code | input | 8 | Error code from memory |
| mem_rsp_rdata | input | 512 | Read data of a line |

## Verification
The hardest situation to reach is an error in the middle of a copy. It has to follow some successful lines so that the completed count and the untouched tail can both be observed. The bench's memory model fails any access to one chosen line. A three-line copy whose second source line is that line then shows one line written, one left intact, and an error word carrying the model's code.

A start arriving while a copy is running is the other hard case. The bench issues it on the cycle after a four-line start, so it falls while the engine is active.

// File: rtl/lcopy_pkg.sv
package lcopy_pkg;
    // register indices
    localparam logic [2:0] RA_SRC = 3'd0;
    localparam logic [2:0] RA_DST = 3'd1;
    localparam logic [2:0] RA_NTF = 3'd2;
    localparam logic [2:0] RA_LEN = 3'd3;
    localparam logic [2:0] RA_CTL = 3'd4;

    // control / status bit positions
    localparam int GO_BIT     = 23;
    localparam int MODE_LSB   = 24;
    localparam int OVR_BIT    = 30;
    localparam int ACT_BIT    = 31;

    // notification word layout
    localparam int NW_ERR_BIT = 63;
    localparam int NW_CNT_LSB = 16;
    localparam int NW_CODE_W  = 8;
    localparam int NOTE_ALIGN = 3;
    localparam int REG_W      = 64;

    typedef enum logic [2:0] {
        S_IDLE, S_RD_REQ, S_RD_WAIT, S_WR_REQ, S_WR_WAIT, S_NT_REQ, S_NT_WAIT
    } seq_state_e;
endpackage

// File: rtl/lcopy_regs.sv
module lcopy_regs
    import lcopy_pkg::*;
#(
    parameter int AW       = 40,
    parameter int LEN_W    = 16,
    parameter int MODE_W   = 8,
    parameter int OFS_W    = 6,
    parameter bit COMBINED = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [2:0]        addr,
    input  logic [REG_W-1:0]  wdata,
    input  logic              active,
    output logic [REG_W-1:0]  rdata,
    output logic [AW-1:0]     src_o,
    output logic [AW-1:0]     dst_o,
    output logic [AW-1:0]     ntf_o,
    output logic              start_o,
    output logic [LEN_W-1:0]  start_cnt_o,
    output logic              ovr_o
);
    localparam logic [AW-1:0] LINE_MSK = {{(AW-OFS_W){1'b1}}, {OFS_W{1'b0}}};
    localparam logic [AW-1:0] NOTE_MSK = {{(AW-NOTE_ALIGN){1'b1}}, {NOTE_ALIGN{1'b0}}};

    typedef struct packed {
        logic [AW-1:0]     src;
        logic [AW-1:0]     dst;
        logic [AW-1:0]     ntf;
        logic [LEN_W-1:0]  cnt;
        logic [MODE_W-1:0] mode;
        logic              ovr;
    } rf_t;

    rf_t r_d, r_q;

    logic              ctl_go;
    logic [LEN_W-1:0]  ctl_cnt;
    logic [MODE_W-1:0] ctl_mode;
    logic              len_wr_ok;
    logic              go_req;

    // start-command decode chosen by variant
    if (COMBINED) begin : g_comb
        assign ctl_go    = wdata[GO_BIT];
        assign ctl_cnt   = wdata[LEN_W-1:0];
        assign ctl_mode  = wdata[MODE_LSB +: MODE_W];
        assign len_wr_ok = 1'b0;
    end else begin : g_split
        assign ctl_go    = 1'b1;
        assign ctl_cnt   = r_q.cnt;
        assign ctl_mode  = wdata[MODE_W-1:0];
        assign len_wr_ok = 1'b1;
    end

    always_comb begin
        r_d    = r_q;
        go_req = 1'b0;
        if (we) begin
            case (addr)
                RA_SRC: r_d.src = wdata[AW-1:0] & LINE_MSK;
                RA_DST: r_d.dst = wdata[AW-1:0] & LINE_MSK;
                RA_NTF: r_d.ntf = wdata[AW-1:0] & NOTE_MSK;
                RA_LEN: if (len_wr_ok) r_d.cnt = wdata[LEN_W-1:0];
                RA_CTL: go_req = ctl_go;
                default: ;
            endcase
        end
        start_o     = go_req && !active;
        start_cnt_o = ctl_cnt;
        if (go_req && active) r_d.ovr = 1'b1;
        if (start_o) begin
            r_d.mode = ctl_mode;
            r_d.cnt  = ctl_cnt;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        rdata = '0;
        case (addr)
            RA_SRC: rdata[AW-1:0] = r_q.src;
            RA_DST: rdata[AW-1:0] = r_q.dst;
            RA_NTF: rdata[AW-1:0] = r_q.ntf;
            RA_LEN: begin
                rdata[LEN_W-1:0] = r_q.cnt;
                rdata[OVR_BIT]   = r_q.ovr;
                rdata[ACT_BIT]   = active;
            end
            RA_CTL: rdata[MODE_W-1:0] = r_q.mode;
            default: ;
        endcase
    end

    assign src_o = r_q.src;
    assign dst_o = r_q.dst;
    assign ntf_o = r_q.ntf;
    assign ovr_o = r_q.ovr;
endmodule

// File: rtl/lcopy_seq.sv
module lcopy_seq
    import lcopy_pkg::*;
#(
    parameter int AW         = 40,
    parameter int LB         = 512,
    parameter int LEN_W      = 16,
    parameter int LINE_BYTES = 64
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [AW-1:0]        src_in,
    input  logic [AW-1:0]        dst_in,
    input  logic [AW-1:0]        ntf_in,
    input  logic [LEN_W-1:0]     cnt_in,
    output logic                 active,
    output logic                 req_valid,
    input  logic                 req_ready,
    output logic                 req_we,
    output logic                 req_word,
    output logic [AW-1:0]        req_addr,
    output logic [LB-1:0]        req_wdata,
    input  logic                 rsp_valid,
    input  logic                 rsp_err,
    input  logic [NW_CODE_W-1:0] rsp_code,
    input  logic [LB-1:0]        rsp_rdata
);
    localparam logic [AW-1:0] STEP = AW'(LINE_BYTES);

    typedef struct packed {
        seq_state_e           state;
        logic [AW-1:0]        src;
        logic [AW-1:0]        dst;
        logic [AW-1:0]        ntf;
        logic [LEN_W-1:0]     left;
        logic [LEN_W-1:0]     done;
        logic [LB-1:0]        line;
        logic                 err;
        logic [NW_CODE_W-1:0] code;
    } sq_t;

    sq_t s_d, s_q;
    logic [REG_W-1:0] note_word;

    always_comb begin
        note_word = '0;
        note_word[NW_ERR_BIT] = s_q.err;
        note_word[NW_CNT_LSB +: LEN_W] = s_q.done;
        if (s_q.err) note_word[NW_CODE_W-1:0] = s_q.code;
        else         note_word[0] = 1'b1;
    end

    always_comb begin
        s_d = s_q;
        case (s_q.state)
            S_IDLE: if (start) begin
                s_d.src   = src_in;
                s_d.dst   = dst_in;
                s_d.ntf   = ntf_in;
                s_d.left  = cnt_in;
                s_d.done  = '0;
                s_d.err   = 1'b0;
                s_d.code  = '0;
                s_d.state = (cnt_in == '0) ? S_NT_REQ : S_RD_REQ;
            end
            S_RD_REQ: if (req_ready) s_d.state = S_RD_WAIT;
            S_RD_WAIT: if (rsp_valid) begin
                if (rsp_err) begin
                    s_d.err   = 1'b1;
                    s_d.code  = rsp_code;
                    s_d.state = S_NT_REQ;
                end else begin
                    s_d.line  = rsp_rdata;
                    s_d.state = S_WR_REQ;
                end
            end
            S_WR_REQ: if (req_ready) s_d.state = S_WR_WAIT;
            S_WR_WAIT: if (rsp_valid) begin
                if (rsp_err) begin
                    s_d.err   = 1'b1;
                    s_d.code  = rsp_code;
                    s_d.state = S_NT_REQ;
                end else begin
                    s_d.done  = s_q.done + 1'b1;
                    s_d.left  = s_q.left - 1'b1;
                    s_d.src   = s_q.src + STEP;
                    s_d.dst   = s_q.dst + STEP;
                    s_d.state = (s_q.left == LEN_W'(1)) ? S_NT_REQ : S_RD_REQ;
                end
            end
            S_NT_REQ: if (req_ready) s_d.state = S_NT_WAIT;
            S_NT_WAIT: if (rsp_valid) s_d.state = S_IDLE;
            default: s_d.state = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.state <= S_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        active    = (s_q.state != S_IDLE);
        req_valid = (s_q.state == S_RD_REQ) || (s_q.state == S_WR_REQ) || (s_q.state == S_NT_REQ);
        req_we    = (s_q.state == S_WR_REQ) || (s_q.state == S_NT_REQ);
        req_word  = (s_q.state == S_NT_REQ);
        case (s_q.state)
            S_RD_REQ: req_addr = s_q.src;
            S_WR_REQ: req_addr = s_q.dst;
            S_NT_REQ: req_addr = s_q.ntf;
            default:  req_addr = '0;
        endcase
        if (s_q.state == S_NT_REQ) req_wdata = {{(LB-REG_W){1'b0}}, note_word};
        else                       req_wdata = s_q.line;
    end
endmodule

// File: rtl/lcopy_engine.sv
module lcopy_engine
    import lcopy_pkg::*;
#(
    parameter int ADDR_W         = 40,
    parameter int LINE_BYTES     = 64,
    parameter int LINE_BITS      = 512,
    parameter int LEN_W          = 16,
    parameter int MODE_W         = 8,
    parameter bit COMBINED_START = 1'b1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_we,
    input  logic [2:0]            reg_addr,
    input  logic [63:0]           reg_wdata,
    output logic [63:0]           reg_rdata,
    output logic                  mem_req_valid,
    input  logic                  mem_req_ready,
    output logic                  mem_req_we,
    output logic                  mem_req_word,
    output logic [ADDR_W-1:0]     mem_req_addr,
    output logic [LINE_BITS-1:0]  mem_req_wdata,
    input  logic                  mem_rsp_valid,
    input  logic                  mem_rsp_err,
    input  logic [7:0]            mem_rsp_code,
    input  logic [LINE_BITS-1:0]  mem_rsp_rdata
);
    localparam int OFS_W = $clog2(LINE_BYTES);

    logic               eng_active;
    logic               ovr_flag;
    logic               start;
    logic [ADDR_W-1:0]  src_a, dst_a, ntf_a;
    logic [LEN_W-1:0]   start_cnt;

    lcopy_regs #(
        .AW(ADDR_W), .LEN_W(LEN_W), .MODE_W(MODE_W),
        .OFS_W(OFS_W), .COMBINED(COMBINED_START)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
        .wdata(reg_wdata), .active(eng_active), .rdata(reg_rdata),
        .src_o(src_a), .dst_o(dst_a), .ntf_o(ntf_a),
        .start_o(start), .start_cnt_o(start_cnt), .ovr_o(ovr_flag)
    );

    lcopy_seq #(
        .AW(ADDR_W), .LB(LINE_BITS), .LEN_W(LEN_W), .LINE_BYTES(LINE_BYTES)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start),
        .src_in(src_a), .dst_in(dst_a), .ntf_in(ntf_a), .cnt_in(start_cnt),
        .active(eng_active),
        .req_valid(mem_req_valid), .req_ready(mem_req_ready),
        .req_we(mem_req_we), .req_word(mem_req_word),
        .req_addr(mem_req_addr), .req_wdata(mem_req_wdata),
        .rsp_valid(mem_rsp_valid), .rsp_err(mem_rsp_err),
        .rsp_code(mem_rsp_code), .rsp_rdata(mem_rsp_rdata)
    );
endmodule

// File: rtl/lcopy_engine_chk.sv
module lcopy_engine_chk #(
    parameter int AW = 40
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mem_req_valid,
    input logic          mem_req_ready,
    input logic          mem_req_we,
    input logic          mem_req_word,
    input logic [AW-1:0] mem_req_addr,
    input logic          mem_rsp_valid,
    input logic          eng_active,
    input logic          ovr_flag
);
    // R5
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we));

    // R5
    line_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_word |-> mem_req_addr[5:0] == 6'd0);

    // R6
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !eng_active |-> !mem_req_valid);

    // R6
    end_on_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(eng_active) |-> $past(mem_rsp_valid));

    // R7
    note_is_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && mem_req_word |-> mem_req_we && mem_req_addr[2:0] == 3'd0);

    // R9
    ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_flag |=> ovr_flag);
endmodule

bind lcopy_engine lcopy_engine_chk #(.AW(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_we(mem_req_we), .mem_req_word(mem_req_word),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .eng_active(eng_active), .ovr_flag(ovr_flag)
);

// File: tb/tb_linemem.sv
module tb_linemem #(
    parameter int AW    = 40,
    parameter int LB    = 512,
    parameter bit STALL = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_we,
    input  logic          req_word,
    input  logic [AW-1:0] req_addr,
    input  logic [LB-1:0] req_wdata,
    output logic          rsp_valid,
    output logic          rsp_err,
    output logic [7:0]    rsp_code,
    output logic [LB-1:0] rsp_rdata,
    input  logic          err_en,
    input  logic [5:0]    err_line
);
    logic [LB-1:0] mem [64];
    logic [63:0]   note_data;
    logic [AW-1:0] note_addr;
    int            note_cnt;
    int            line_wr;
    logic          tick;

    function automatic logic [LB-1:0] pat(input int i);
        return {(LB/32){32'hA500_0000 | i}};
    endfunction

    assign req_ready = STALL ? tick : 1'b1;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 64; i++) mem[i] <= pat(i);
            note_data <= '0; note_addr <= '0; note_cnt <= 0; line_wr <= 0;
            tick <= 1'b0; rsp_valid <= 1'b0; rsp_err <= 1'b0;
            rsp_code <= '0; rsp_rdata <= '0;
        end else begin
            tick      <= ~tick;
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            if (req_valid && req_ready) begin
                rsp_valid <= 1'b1;
                if (req_word) begin
                    note_addr <= req_addr;
                    note_data <= req_wdata[63:0];
                    note_cnt  <= note_cnt + 1;
                end else if (err_en && req_addr[11:6] == err_line) begin
                    rsp_err  <= 1'b1;
                    rsp_code <= 8'h5A;
                end else if (req_we) begin
                    mem[req_addr[11:6]] <= req_wdata;
                    line_wr <= line_wr + 1;
                end else begin
                    rsp_rdata <= mem[req_addr[11:6]];
                end
            end
        end
    end
endmodule

// File: tb/tb_lcopy_engine.sv
`timescale 1ns/1ps
module tb_lcopy_engine;
    localparam int AW = 40;
    localparam int LB = 512;
    localparam logic [2:0] A_SRC = 3'd0, A_DST = 3'd1, A_NTF = 3'd2, A_LEN = 3'd3, A_CTL = 3'd4;
    localparam logic [63:0] GO = 64'h0080_0000;
    // table: source line, destination line, line count
    localparam int NV = 4;
    localparam int VEC [NV][3] = '{'{0, 32, 1}, '{2, 40, 4}, '{5, 44, 3}, '{1, 60, 2}};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic [2:0]  ra = '0;
    logic [63:0] rw = '0;
    logic        we_a = 1'b0, we_b = 1'b0;
    logic [63:0] rd_a, rd_b;
    logic        err_en = 1'b0;
    logic [5:0]  err_line = '0;

    logic a_rv, a_rr, a_we, a_wd, a_sv, a_se; logic [AW-1:0] a_ad; logic [LB-1:0] a_wdat, a_rdat; logic [7:0] a_sc;
    logic b_rv, b_rr, b_we, b_wd, b_sv, b_se; logic [AW-1:0] b_ad; logic [LB-1:0] b_wdat, b_rdat; logic [7:0] b_sc;

    lcopy_engine dut (
        .clk(clk), .rst_n(rst_n), .reg_we(we_a), .reg_addr(ra), .reg_wdata(rw), .reg_rdata(rd_a),
        .mem_req_valid(a_rv), .mem_req_ready(a_rr), .mem_req_we(a_we), .mem_req_word(a_wd),
        .mem_req_addr(a_ad), .mem_req_wdata(a_wdat), .mem_rsp_valid(a_sv), .mem_rsp_err(a_se),
        .mem_rsp_code(a_sc), .mem_rsp_rdata(a_rdat));
    tb_linemem #(.AW(AW), .LB(LB), .STALL(1'b0)) u_mem_a (
        .clk(clk), .rst_n(rst_n), .req_valid(a_rv), .req_ready(a_rr), .req_we(a_we), .req_word(a_wd),
        .req_addr(a_ad), .req_wdata(a_wdat), .rsp_valid(a_sv), .rsp_err(a_se), .rsp_code(a_sc),
        .rsp_rdata(a_rdat), .err_en(err_en), .err_line(err_line));

    lcopy_engine #(.COMBINED_START(1'b0)) dut_split (
        .clk(clk), .rst_n(rst_n), .reg_we(we_b), .reg_addr(ra), .reg_wdata(rw), .reg_rdata(rd_b),
        .mem_req_valid(b_rv), .mem_req_ready(b_rr), .mem_req_we(b_we), .mem_req_word(b_wd),
        .mem_req_addr(b_ad), .mem_req_wdata(b_wdat), .mem_rsp_valid(b_sv), .mem_rsp_err(b_se),
        .mem_rsp_code(b_sc), .mem_rsp_rdata(b_rdat));
    tb_linemem #(.AW(AW), .LB(LB), .STALL(1'b1)) u_mem_b (
        .clk(clk), .rst_n(rst_n), .req_valid(b_rv), .req_ready(b_rr), .req_we(b_we), .req_word(b_wd),
        .req_addr(b_ad), .req_wdata(b_wdat), .rsp_valid(b_sv), .rsp_err(b_se), .rsp_code(b_sc),
        .rsp_rdata(b_rdat), .err_en(1'b0), .err_line(6'd0));

    int errors = 0;
    int checks = 0;
    int cyc = 0;

    function automatic logic [LB-1:0] pat(input int i);
        return {(LB/32){32'hA500_0000 | i}};
    endfunction

    function automatic logic [63:0] okword(input int n);
        return (64'(n) << 16) | 64'h1;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk_eq(input string tag, input logic [63:0] act, input logic [63:0] exp);
        chk(act === exp, tag, act, exp);
    endtask

    task automatic wr(input bit b, input logic [2:0] a, input logic [63:0] d);
        @(negedge clk);
        ra = a; rw = d;
        if (b) we_b = 1'b1; else we_a = 1'b1;
        @(negedge clk);
        we_a = 1'b0; we_b = 1'b0;
    endtask

    task automatic rd(input bit b, input logic [2:0] a, output logic [63:0] d);
        @(negedge clk);
        ra = a;
        #1;
        d = b ? rd_b : rd_a;
    endtask

    task automatic wait_idle(input bit b, input string tag);
        logic [63:0] v;
        v = '1;
        for (int i = 0; i < 3000; i++) begin
            rd(b, A_LEN, v);
            if (!v[31]) break;
        end
        chk_eq(tag, 64'(v[31]), 64'd0);
    endtask

    task automatic setup(input bit b, input logic [63:0] s, input logic [63:0] d, input logic [63:0] n);
        wr(b, A_SRC, s);
        wr(b, A_DST, d);
        wr(b, A_NTF, n);
    endtask

    initial begin : watchdog
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                errors++; checks++;
                $display("FAIL watchdog expired actual=%0d expected=done", cyc);
                $display("Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
        end
    end

    initial begin : main
        logic [63:0] v;
        int nc, lw;
        repeat (5) @(negedge clk);
        // R1 reset state
        rd(1'b0, A_LEN, v);
        chk_eq("R1 status after reset", v, 64'd0);
        chk_eq("R1 no request in reset", 64'(a_rv), 64'd0);
        @(negedge clk); rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // table of copies: R5 data, R6 active, R7 notification
        for (int k = 0; k < NV; k++) begin
            setup(1'b0, 64'(VEC[k][0] * 64), 64'(VEC[k][1] * 64), 64'h2000);
            wr(1'b0, A_CTL, GO | 64'(VEC[k][2]));
            rd(1'b0, A_LEN, v);
            chk_eq("R6 active after start", 64'(v[31]), 64'd1);
            wait_idle(1'b0, "R6 returns idle");
            for (int j = 0; j < VEC[k][2]; j++)
                chk(u_mem_a.mem[VEC[k][1] + j] === pat(VEC[k][0] + j), "R5 line copied",
                    u_mem_a.mem[VEC[k][1] + j][63:0], pat(VEC[k][0] + j)[63:0]);
            chk_eq("R7 success word", u_mem_a.note_data, okword(VEC[k][2]));
            chk_eq("R7 notify address", 64'(u_mem_a.note_addr), 64'h2000);
        end

        // R3 mode readback and go flag
        setup(1'b0, 64'(10 * 64), 64'(30 * 64), 64'h2000);
        wr(1'b0, A_CTL, GO | (64'h5C << 24) | 64'd1);
        wait_idle(1'b0, "R3 idle");
        rd(1'b0, A_CTL, v);
        chk_eq("R3 mode readback", v, 64'h5C);
        chk(u_mem_a.mem[30] === pat(10), "R3 combined copy", u_mem_a.mem[30][63:0], pat(10)[63:0]);
        nc = u_mem_a.note_cnt;
        wr(1'b0, A_CTL, 64'd2);
        rd(1'b0, A_LEN, v);
        chk_eq("R3 no go flag stays idle", 64'(v[31]), 64'd0);
        repeat (10) @(negedge clk);
        chk_eq("R3 no go flag no notify", 64'(u_mem_a.note_cnt), 64'(nc));

        // R2 offset bits and count mask
        setup(1'b0, 64'(3 * 64 + 'h17), 64'(50 * 64 + 'h2B), 64'h2005);
        rd(1'b0, A_SRC, v);
        chk_eq("R2 source masked", v, 64'hC0);
        wr(1'b0, A_CTL, GO | 64'h7_0002);
        wait_idle(1'b0, "R2 idle");
        chk(u_mem_a.mem[50] === pat(3) && u_mem_a.mem[51] === pat(4), "R2 aligned copy",
            u_mem_a.mem[51][63:0], pat(4)[63:0]);
        chk_eq("R2 masked count", u_mem_a.note_data, okword(2));
        chk_eq("R2 notify addr masked", 64'(u_mem_a.note_addr), 64'h2000);

        // R9 start while active
        setup(1'b0, 64'(9 * 64), 64'(24 * 64), 64'h2000);
        wr(1'b0, A_CTL, GO | 64'd4);
        wr(1'b0, A_CTL, GO | 64'd1);
        rd(1'b0, A_LEN, v);
        chk_eq("R9 overrun flag", 64'(v[30]), 64'd1);
        wait_idle(1'b0, "R9 idle");
        chk_eq("R9 first copy unaffected", u_mem_a.note_data, okword(4));
        chk(u_mem_a.mem[27] === pat(12), "R9 all lines", u_mem_a.mem[27][63:0], pat(12)[63:0]);

        // R10 zero count
        nc = u_mem_a.note_cnt; lw = u_mem_a.line_wr;
        wr(1'b0, A_CTL, GO);
        wait_idle(1'b0, "R10 idle");
        chk_eq("R10 no line writes", 64'(u_mem_a.line_wr), 64'(lw));
        chk_eq("R10 one notification", 64'(u_mem_a.note_cnt), 64'(nc + 1));
        chk_eq("R10 zero count word", u_mem_a.note_data, okword(0));
        rd(1'b0, A_LEN, v);
        chk_eq("R9 overrun sticky", 64'(v[30]), 64'd1);

        // R8 error mid-copy
        err_en = 1'b1; err_line = 6'd7;
        setup(1'b0, 64'(6 * 64), 64'(20 * 64), 64'h2100);
        wr(1'b0, A_CTL, GO | 64'd3);
        wait_idle(1'b0, "R8 idle");
        chk_eq("R8 error word", u_mem_a.note_data, 64'h8000_0000_0001_005A);
        chk(u_mem_a.mem[20] === pat(6), "R8 earlier line kept", u_mem_a.mem[20][63:0], pat(6)[63:0]);
        chk(u_mem_a.mem[21] === pat(21) && u_mem_a.mem[22] === pat(22), "R8 later lines untouched",
            u_mem_a.mem[21][63:0], pat(21)[63:0]);
        err_en = 1'b0;

        // R4 split start with back-pressure
        wr(1'b1, A_LEN, 64'd2);
        rd(1'b1, A_LEN, v);
        chk_eq("R4 count readback", v, 64'd2);
        setup(1'b1, 64'(8 * 64), 64'(56 * 64), 64'h2000);
        wr(1'b1, A_CTL, 64'h33);
        rd(1'b1, A_LEN, v);
        chk_eq("R4 active after control", 64'(v[31]), 64'd1);
        wait_idle(1'b1, "R4 idle");
        chk(u_mem_b.mem[56] === pat(8) && u_mem_b.mem[57] === pat(9), "R4 split copy",
            u_mem_b.mem[57][63:0], pat(9)[63:0]);
        chk_eq("R4 split notification", u_mem_b.note_data, okword(2));
        rd(1'b1, A_CTL, v);
        chk_eq("R4 mode readback", v, 64'h33);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule